// File: doc/BRIEF.md
# Dual-Path Watchdog Timer

This block is a counter that watches for a stalled program. Once it is started, it counts up on every peripheral clock cycle. It compares its value with a programmable limit. Software must restart the count with a two-write key sequence before the limit is reached. If the limit is reached in watchdog mode, the active-low match output falls and the counter freezes.

The match can then request a reset in two ways, and each can be enabled on its own. The first is a level that resets only the chip's internals. The second is a pulse of programmable length on the external active-low reset line, which resets the internals too. A sticky flag records that a watchdog reset was requested. The flag sits in an always-on reset domain, so it survives the core reset it caused.

With watchdog mode off, the same counter is a free-running timer that raises an interrupt flag on a match. A debug-halt input freezes counting in both modes.

Top module: `wdog_dual_reset`

## Requirements
- R1: While CTRL.run (bit 0 of CTRL, address 0) is 1 and `dbg_halt` is 0, the count (readable at address 4) increases by one every clock. Each cycle with `dbg_halt` high delays a watchdog match by exactly one cycle.
- R2: With CTRL.wd (bit 1) set, a match value M written at address 1 makes `match_n` fall M+1 clocks after the clock edge that writes CTRL. From then on the counter holds and `match_n` stays low until `rst_n` is asserted.
- R3: With CTRL.int_en (bit 2) set, `int_rst_n` is low while `match_n` is low. With CTRL.ext_en (bit 3) clear, `ext_rst_n` stays high.
- R4: With CTRL.ext_en set, `ext_rst_n` goes low in the same cycle as `match_n` and stays low for exactly W clocks, where W is the 16-bit width at address 2. A width of 0 gives no pulse.
- R5: `int_rst_n` is low whenever `ext_rst_n` is low.
- R6: Writing 0xAA and then 0x55 to address 3 clears the count. Any other write in between, including a different value to address 3, cancels the sequence and leaves the count unchanged.
- R7: STATUS bit 1 (address 5) sets when a watchdog match fires with int_en or ext_en set. It survives `rst_n`. It clears only when 1 is written to it or when `por_n` is asserted.
- R8: With CTRL.wd clear, a match sets `tmr_irq` (STATUS bit 0) and keeps `match_n`, `int_rst_n` and `ext_rst_n` high. The counter keeps running. Writing 1 to STATUS bit 0 clears the flag.
- R9: In watchdog mode with both enables clear, a match drives `match_n` low. Both reset outputs stay high and STATUS bit 1 stays clear.
- R10: After reset, CTRL is 0, the count is 0, STATUS is 0, and all active-low outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Core reset, active low |
| por_n | input | 1 | Always-on reset for the reset-occurred flag, active low |
| dbg_halt | input | 1 | Freezes counting while high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| match_n | output | 1 | Watchdog match, active low |
| int_rst_n | output | 1 | Internal chip reset request, active low |
| ext_rst_n | output | 1 | External reset pulse, active low |
| tmr_irq | output | 1 | Timer-mode match interrupt flag |

## Verification
The bench sweeps small match values against every pulse width from 0 to 3, on both reset paths, and measures the cycle at which the match fires and the pulse length to the exact clock. A design off by one in the compare or the pulse counter fails the cycle count. A width-0 pulse that lasted one cycle would also fail.

Key sequences are tried with an intervening write to another register and with a wrong key value. A design that kept the arm state across those writes would clear a frozen count it must keep.

The reset flag is checked across a core reset and across a power-on reset. A flag placed in the core domain would vanish after `rst_n`.

Timer mode is checked for a counter that keeps running and for reset outputs that stay quiet.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MATCH  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PULSE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_KEY    = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;
    localparam logic [7:0] KEY_ARM  = 8'hAA;
    localparam logic [7:0] KEY_FIRE = 8'h55;

    typedef struct packed {
        logic ext_en;
        logic int_en;
        logic wd_mode;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PW_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              irq_i,
    input  logic              rflag_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  match_o,
    output logic [PW_W-1:0]   pw_o,
    output logic              reload_o,
    output logic              irq_clr_o,
    output logic              rflag_clr_o,
    output logic [CNT_W-1:0]  rdata_o
);
    localparam logic [CNT_W-1:0] ARM_W  = {{(CNT_W-8){1'b0}}, KEY_ARM};
    localparam logic [CNT_W-1:0] FIRE_W = {{(CNT_W-8){1'b0}}, KEY_FIRE};

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  match;
        logic [PW_W-1:0]   pw;
        logic              armed;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        reload_o    = 1'b0;
        irq_clr_o   = 1'b0;
        rflag_clr_o = 1'b0;
        if (wr_en) begin
            s_d.armed = 1'b0;
            case (addr)
                A_CTRL:   s_d.ctrl  = ctrl_t'(wdata[3:0]);
                A_MATCH:  s_d.match = wdata;
                A_PULSE:  s_d.pw    = wdata[PW_W-1:0];
                A_KEY: begin
                    if (wdata == ARM_W)
                        s_d.armed = 1'b1;
                    else if (wdata == FIRE_W && s_q.armed)
                        reload_o = 1'b1;
                end
                A_STATUS: begin
                    irq_clr_o   = wdata[0];
                    rflag_clr_o = wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:   rdata_o = {{(CNT_W-4){1'b0}}, s_q.ctrl};
            A_MATCH:  rdata_o = s_q.match;
            A_PULSE:  rdata_o = {{(CNT_W-PW_W){1'b0}}, s_q.pw};
            A_COUNT:  rdata_o = count_i;
            A_STATUS: rdata_o = {{(CNT_W-2){1'b0}}, rflag_i, irq_i};
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl  <= '0;
            s_q.match <= '1;
            s_q.pw    <= '0;
            s_q.armed <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o  = s_q.ctrl;
    assign match_o = s_q.match;
    assign pw_o    = s_q.pw;

    // R6
    key_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> !s_q.armed);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_i,
    input  logic [CNT_W-1:0] match_i,
    input  logic             halt_i,
    input  logic             reload_i,
    input  logic             irq_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             fired_o,
    output logic             fire_evt_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             fired;
        logic             irq;
    } core_t;

    core_t s_d, s_q;
    logic  tick, hit;

    always_comb begin
        s_d        = s_q;
        tick       = ctrl_i.run && !halt_i && !s_q.fired;
        hit        = tick && (s_q.count == match_i);
        fire_evt_o = hit && ctrl_i.wd_mode && !reload_i;
        if (reload_i)
            s_d.count = '0;
        else if (tick && !fire_evt_o)
            s_d.count = s_q.count + 1'b1;
        if (fire_evt_o)
            s_d.fired = 1'b1;
        if (irq_clr_i)
            s_d.irq = 1'b0;
        if (hit && !ctrl_i.wd_mode)
            s_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.count;
    assign fired_o = s_q.fired;
    assign irq_o   = s_q.irq;

    // R1
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !reload_i) |=> $stable(s_q.count));
    // R2
    fired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fired |=> s_q.fired);
    // R2
    fired_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fired && !reload_i) |=> $stable(s_q.count));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int PW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [PW_W-1:0] width_i,
    output logic            active_o
);
    typedef struct packed {
        logic [PW_W-1:0] left;
    } pulse_t;

    pulse_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i)
            s_d.left = width_i;
        else if (s_q.left != '0)
            s_d.left = s_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = (s_q.left != '0);

    // R4
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> $past(load_i));
endmodule

// File: rtl/wdog_sticky.sv
module wdog_sticky (
    input  logic clk,
    input  logic por_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } sticky_t;

    sticky_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) s_d.flag = 1'b0;
        if (set_i) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o = s_q.flag;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        set_i |=> flag_o);
    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/wdog_dual_reset.sv
module wdog_dual_reset
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PW_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              dbg_halt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              match_n,
    output logic              int_rst_n,
    output logic              ext_rst_n,
    output logic              tmr_irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] match_v, count_v;
    logic [PW_W-1:0]  pw;
    logic             reload, irq_clr, rflag_clr, rflag;
    logic             fired, fire_evt, irq, pulse_on;
    logic             pulse_load, rflag_set;

    wdog_regs #(.CNT_W(CNT_W), .PW_W(PW_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count_i(count_v), .irq_i(irq), .rflag_i(rflag),
        .ctrl_o(ctrl), .match_o(match_v), .pw_o(pw), .reload_o(reload),
        .irq_clr_o(irq_clr), .rflag_clr_o(rflag_clr), .rdata_o(rdata)
    );

    wdog_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .match_i(match_v),
        .halt_i(dbg_halt), .reload_i(reload), .irq_clr_i(irq_clr),
        .count_o(count_v), .fired_o(fired), .fire_evt_o(fire_evt), .irq_o(irq)
    );

    assign pulse_load = fire_evt && ctrl.ext_en;
    assign rflag_set  = fire_evt && (ctrl.int_en || ctrl.ext_en);

    wdog_pulse #(.PW_W(PW_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .load_i(pulse_load), .width_i(pw),
        .active_o(pulse_on)
    );

    wdog_sticky u_sticky (
        .clk(clk), .por_n(por_n), .set_i(rflag_set), .clr_i(rflag_clr),
        .flag_o(rflag)
    );

    assign match_n   = !fired;
    assign ext_rst_n = !pulse_on;
    assign int_rst_n = !((fired && ctrl.int_en) || pulse_on);
    assign tmr_irq   = irq;

    // R5
    ext_implies_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst_n |-> !int_rst_n);
    // R8
    timer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.wd_mode && !fired) |=> (ext_rst_n || !$stable(ctrl)));
endmodule

// File: tb/test_wdog_dual_reset.sv
module test_wdog_dual_reset;
    import wdog_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0, dbg_halt = 1'b0, wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        match_n, int_rst_n, ext_rst_n, tmr_irq;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    wdog_dual_reset i_wdog_dual_reset (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .dbg_halt(dbg_halt),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .match_n(match_n), .int_rst_n(int_rst_n), .ext_rst_n(ext_rst_n),
        .tmr_irq(tmr_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic core_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wait_match(output int n);
        n = 0;
        while (match_n !== 1'b0 && n < 200) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic trial(input int m, input int w, input logic [3:0] ctl);
        int n, pc;
        logic [31:0] v;
        core_reset();
        wr(A_MATCH, m); wr(A_PULSE, w); wr(A_CTRL, {28'd0, ctl});
        wait_match(n);
        chk("R2 match latency", n, m + 1);
        pc = 0;
        while (ext_rst_n === 1'b0 && pc < 100) begin
            if (pc == 0) chk("R5 int low in pulse", int_rst_n, 0);
            pc++; @(negedge clk);
        end
        chk("R4 pulse width", pc, ctl[3] ? w : 0);
        chk("R3 int level after pulse", int_rst_n, ctl[2] ? 0 : 1);
        rd(A_COUNT, v);
        chk("R2 count frozen", v, m);
        rd(A_STATUS, v);
        chk("R7 reset flag set", v[1], (ctl[2] | ctl[3]) ? 1 : 0);
        wr(A_STATUS, 32'h2);
        rd(A_STATUS, v);
        chk("R7 flag W1C", v[1], 0);
    endtask

    initial begin
        logic [31:0] v, frozen;
        int n;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 match_n", match_n, 1); chk("R10 int_rst_n", int_rst_n, 1);
        chk("R10 ext_rst_n", ext_rst_n, 1); chk("R10 tmr_irq", tmr_irq, 0);
        rd(A_CTRL, v);   chk("R10 ctrl", v, 0);
        rd(A_COUNT, v);  chk("R10 count", v, 0);
        rd(A_STATUS, v); chk("R10 status", v, 0);

        // R2 R3 R4 sweep: external path, internal path, both
        for (int m = 0; m < 6; m++)
            for (int w = 0; w < 4; w++)
                trial(m, w, 4'b1011);
        for (int m = 0; m < 4; m++) trial(m, 2, 4'b0111);
        for (int m = 0; m < 4; m++) trial(m, 3, 4'b1111);

        // R9 no enables
        core_reset();
        wr(A_MATCH, 2); wr(A_CTRL, 32'b0011);
        wait_match(n);
        chk("R9 latency", n, 3);
        chk("R9 int high", int_rst_n, 1); chk("R9 ext high", ext_rst_n, 1);
        rd(A_STATUS, v); chk("R9 no flag", v[1], 0);

        // R1 debug halt
        core_reset();
        wr(A_MATCH, 4); wr(A_CTRL, 32'b0011);
        dbg_halt = 1'b1; n = 0;
        repeat (3) begin @(negedge clk); n++; end
        dbg_halt = 1'b0;
        begin
            int k;
            wait_match(k);
            chk("R1 halt delays match", n + k, 8);
        end

        // R8 timer mode
        core_reset();
        wr(A_MATCH, 3); wr(A_CTRL, 32'b1101);
        n = 0;
        while (tmr_irq !== 1'b1 && n < 100) begin @(negedge clk); n++; end
        chk("R8 irq latency", n, 4);
        chk("R8 match_n high", match_n, 1);
        chk("R8 ext high", ext_rst_n, 1); chk("R8 int high", int_rst_n, 1);
        rd(A_COUNT, v); chk("R8 counter runs", v, 4);
        rd(A_STATUS, v); chk("R8 status irq", v[0], 1);
        wr(A_STATUS, 32'h1);
        chk("R8 irq W1C", tmr_irq, 0);

        // R6 reload key sequence with frozen counter
        core_reset();
        wr(A_MATCH, 1000); wr(A_CTRL, 32'b0001);
        repeat (10) @(negedge clk);
        wr(A_CTRL, 32'b0000);
        rd(A_COUNT, frozen);
        chk("R1 counted", (frozen > 10) ? 1 : 0, 1);
        wr(A_KEY, 32'hAA); wr(A_MATCH, 1000); wr(A_KEY, 32'h55);
        rd(A_COUNT, v); chk("R6 abort by other reg", v, frozen);
        wr(A_KEY, 32'hAA); wr(A_KEY, 32'h12); wr(A_KEY, 32'h55);
        rd(A_COUNT, v); chk("R6 abort by bad key", v, frozen);
        wr(A_KEY, 32'h55);
        rd(A_COUNT, v); chk("R6 lone second key", v, frozen);
        wr(A_KEY, 32'hAA); wr(A_KEY, 32'h55);
        rd(A_COUNT, v); chk("R6 reload clears", v, 0);

        // R6 periodic reload keeps the watchdog quiet
        core_reset();
        wr(A_MATCH, 6); wr(A_CTRL, 32'b0111);
        for (int i = 0; i < 6; i++) begin
            wr(A_KEY, 32'hAA); wr(A_KEY, 32'h55);
            chk("R6 no match while serviced", match_n, 1);
        end
        wait_match(n);
        chk("R6 match after service stops", n, 7);

        // R7 flag survives core reset, cleared by por_n
        rd(A_STATUS, v); chk("R7 flag after fire", v[1], 1);
        core_reset();
        rd(A_STATUS, v); chk("R7 survives rst_n", v[1], 1);
        chk("R7 outputs released", int_rst_n & match_n, 1);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd(A_STATUS, v); chk("R7 cleared by por_n", v[1], 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule